// File: doc/BRIEF.md
# SPI Flash Command Shifter

This block sends one short, arbitrary command to a serial flash and collects whatever the flash sends back. Software fills up to six transmit byte registers, writes the total transaction length in bits to a count register, then sets a start bit in the command register. The engine pulls chip select low, clocks the counted number of bits out on one data line, MSB first in SPI mode 0, and samples the return line on every rising serial clock edge. When the count runs out it releases chip select and clears the start bit. Completion is therefore signalled by that bit reading back as zero.

Received data is read from a separate bank of ten byte registers, indexed from the end of the transaction. A second command bit runs a status-write transaction through the same count and data registers. When a status write completes and the enable bit is set, a sticky interrupt flag is raised. The serial clock has no programmable divider. It toggles on every core clock cycle, so one bit takes two core cycles.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register word addresses are 0 command, 1 bit count, 2 interrupt status, 3 interrupt enable, 8+i transmit byte i (i = 0..5) and 16+j receive byte j (j = 0..9). After reset every register reads 0, chip select is high, the serial clock is low and the irq output is low.
- R2: Writing the command register with bit 2 set, while idle and with a nonzero count N, drives chip select low from the next clock edge for exactly 2N core cycles. During that time the serial clock is low in the first cycle of each bit and high in the second.
- R3: The output line carries transmit byte 5 MSB first, then bytes 4 down to 0, and zeros once all 48 loaded bits are sent. Each bit is valid from the start of its low cycle.
- R4: The input line is sampled on each rising serial clock edge. After completion, receive byte j holds the bits that ended 8j bits before the end of the transaction (last bit in bit 0). An n-byte reply therefore has its first byte at index n-1 and its last byte at index 0. Bits never captured read 0.
- R5: Command register bit 2 reads 1 from the cycle after the start write through the last cycle of the transaction, and reads 0 afterwards.
- R6: Writing the command register with bit 5 set (and bit 2 clear) runs the same transaction as a status write. While it is busy, bit 5 reads 1 and bit 2 reads 0.
- R7: Interrupt status bit 5 and the irq output become 1 in the cycle after a status write completes, provided interrupt enable bit 5 is 1. Writing 1 to status bit 5 clears it. A bit-2 command never sets the flag.
- R8: A command register write while busy is ignored: the running transaction keeps its kind and length.
- R9: A start with a count of 0 never lowers chip select and reads idle at once. If it is a status write with the enable set, the interrupt flag still sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the serial clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| irq | output | 1 | Status-write completion flag |

## Verification
The assertions assume the flash changes its return line only while the serial clock is low, and that register writes last one cycle each. The bench's flash model updates the line only at the falling core clock edge of a low serial clock cycle, and every register access goes through tasks that drive at the falling edge and hold the strobe for a single rising edge. The assertions also assume no reset pulse arrives in the middle of a transaction, and the bench resets only once, at the start.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
    localparam int DW = 8;
    localparam int AW = 5;

    localparam logic [AW-1:0] A_CMD   = 5'd0;
    localparam logic [AW-1:0] A_CNT   = 5'd1;
    localparam logic [AW-1:0] A_ISTAT = 5'd2;
    localparam logic [AW-1:0] A_IEN   = 5'd3;
    localparam logic [AW-1:0] A_TX0   = 5'd8;
    localparam logic [AW-1:0] A_RX0   = 5'd16;

    localparam int B_PROG = 2;
    localparam int B_WRSR = 5;
    localparam int B_IRQ  = 5;

    typedef enum logic {
        K_PROG = 1'b0,
        K_WRSR = 1'b1
    } kind_e;
endpackage

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int NTX = 6,
    parameter int NRX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              busy_i,
    input  kind_e             kind_i,
    input  logic              fin_i,
    input  kind_e             fin_kind_i,
    input  logic [NRX*8-1:0]  rx_i,
    output logic              start_o,
    output kind_e             start_kind_o,
    output logic [DW-1:0]     count_o,
    output logic [NTX*8-1:0]  tx_o,
    output logic              irq_o
);
    localparam int RXW = NRX * 8;

    typedef struct packed {
        logic [DW-1:0]         count;
        logic [NTX-1:0][7:0]   tx;
        logic                  stat;
        logic                  en;
    } regs_t;

    regs_t q, d;
    logic [7:0] rx_b [NRX];

    for (genvar g = 0; g < NRX; g++) begin : g_rx
        assign rx_b[g] = rx_i[8*g +: 8];
    end

    always_comb begin
        d            = q;
        start_o      = 1'b0;
        start_kind_o = K_PROG;
        if (we) begin
            if (addr == A_CMD && !busy_i) begin
                if (wdata[B_PROG]) begin
                    start_o      = 1'b1;
                    start_kind_o = K_PROG;
                end else if (wdata[B_WRSR]) begin
                    start_o      = 1'b1;
                    start_kind_o = K_WRSR;
                end
            end
            if (addr == A_CNT) d.count = wdata;
            if (addr == A_ISTAT && wdata[B_IRQ]) d.stat = 1'b0;
            if (addr == A_IEN) d.en = wdata[B_IRQ];
            for (int i = 0; i < NTX; i++) begin
                if (addr == AW'(A_TX0 + i)) d.tx[i] = wdata;
            end
        end
        if (fin_i && fin_kind_i == K_WRSR && q.en) d.stat = 1'b1;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CMD) begin
            rdata[B_PROG] = busy_i && (kind_i == K_PROG);
            rdata[B_WRSR] = busy_i && (kind_i == K_WRSR);
        end
        if (addr == A_CNT)   rdata = q.count;
        if (addr == A_ISTAT) rdata[B_IRQ] = q.stat;
        if (addr == A_IEN)   rdata[B_IRQ] = q.en;
        for (int i = 0; i < NTX; i++) begin
            if (addr == AW'(A_TX0 + i)) rdata = q.tx[i];
        end
        for (int j = 0; j < NRX; j++) begin
            if (addr == AW'(A_RX0 + j)) rdata = rx_b[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.count <= '0;
            q.tx    <= '0;
            q.stat  <= 1'b0;
            q.en    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count_o = q.count;
    assign tx_o    = q.tx;
    assign irq_o   = q.stat;

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat) |-> ($past(fin_i) && $past(q.en)));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.stat) |-> ($past(we) && $past(addr) == A_ISTAT));

    logic unused_rx;
    assign unused_rx = ^rx_i[RXW-1:0] & 1'b0;
endmodule

// File: rtl/spi_cmd_shift.sv
`timescale 1ns/1ps
module spi_cmd_shift
    import spi_cmd_pkg::*;
#(
    parameter int NTX = 6,
    parameter int NRX = 10,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  kind_e             kind_i,
    input  logic [CW-1:0]     count_i,
    input  logic [NTX*8-1:0]  tx_i,
    input  logic              miso_i,
    output logic              busy_o,
    output kind_e             kind_o,
    output logic              fin_o,
    output kind_e             fin_kind_o,
    output logic [NRX*8-1:0]  rx_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o
);
    localparam int TXW = NTX * 8;
    localparam int RXW = NRX * 8;

    typedef struct packed {
        logic            busy;
        kind_e           kind;
        logic            sclk;
        logic            cs_n;
        logic [CW-1:0]   rem;
        logic [TXW-1:0]  sh;
        logic [RXW-1:0]  rx;
    } st_t;

    st_t q, d;
    logic fin;

    always_comb begin
        d          = q;
        fin        = 1'b0;
        fin_kind_o = q.kind;
        if (!q.busy) begin
            if (start_i) begin
                if (count_i == '0) begin
                    fin        = 1'b1;
                    fin_kind_o = kind_i;
                end else begin
                    d.busy = 1'b1;
                    d.kind = kind_i;
                    d.rem  = count_i;
                    d.sh   = tx_i;
                    d.rx   = '0;
                    d.sclk = 1'b0;
                    d.cs_n = 1'b0;
                end
            end
        end else if (!q.sclk) begin
            d.sclk = 1'b1;
            d.rx   = {q.rx[RXW-2:0], miso_i};
        end else begin
            d.sclk = 1'b0;
            d.rem  = q.rem - CW'(1);
            d.sh   = {q.sh[TXW-2:0], 1'b0};
            if (q.rem == CW'(1)) begin
                d.busy = 1'b0;
                d.cs_n = 1'b1;
                d.sh   = '0;
                fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.kind <= K_PROG;
            q.sclk <= 1'b0;
            q.cs_n <= 1'b1;
            q.rem  <= '0;
            q.sh   <= '0;
            q.rx   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign kind_o = q.kind;
    assign fin_o  = fin;
    assign rx_o   = q.rx;
    assign sclk_o = q.sclk;
    assign cs_n_o = q.cs_n;
    assign mosi_o = q.sh[TXW-1];

    // R2
    sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    // R2
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !q.sclk) |=> (q.busy && q.sclk));

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !q.sclk) |=> $stable(mosi_o));

    // R8
    kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !fin) |=> (q.busy && $stable(q.kind)));

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.sclk && !fin) |=> (q.rem == $past(q.rem) - CW'(1)));
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int NTX = 6,
    parameter int NRX = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          irq
);
    localparam int TXW = NTX * 8;
    localparam int RXW = NRX * 8;

    logic            start;
    kind_e           start_kind;
    logic [DW-1:0]   count;
    logic [TXW-1:0]  tx;
    logic            busy;
    kind_e           kind;
    logic            fin;
    kind_e           fin_kind;
    logic [RXW-1:0]  rx;

    spi_cmd_regs #(.NTX(NTX), .NRX(NRX)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .busy_i       (busy),
        .kind_i       (kind),
        .fin_i        (fin),
        .fin_kind_i   (fin_kind),
        .rx_i         (rx),
        .start_o      (start),
        .start_kind_o (start_kind),
        .count_o      (count),
        .tx_o         (tx),
        .irq_o        (irq)
    );

    spi_cmd_shift #(.NTX(NTX), .NRX(NRX), .CW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .kind_i     (start_kind),
        .count_i    (count),
        .tx_i       (tx),
        .miso_i     (spi_miso),
        .busy_o     (busy),
        .kind_o     (kind),
        .fin_o      (fin),
        .fin_kind_o (fin_kind),
        .rx_o       (rx),
        .sclk_o     (spi_sclk),
        .cs_n_o     (spi_cs_n),
        .mosi_o     (spi_mosi)
    );
endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi, irq;
    logic       spi_miso = 1'b0;

    spi_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    bit mtx [0:255];
    bit mrx [0:255];
    int b_count = 0;
    int m_N = 0;
    int m_k = 0;
    bit m_act = 0;
    bit pend = 0;
    logic [7:0] b_tx [0:5];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // reference model: state after each rising edge
    always @(posedge clk) begin
        if (m_act) begin
            m_k++;
            if (m_k == 2 * m_N) m_act = 0;
        end else if (pend && b_count > 0) begin
            m_act = 1;
            m_k = 0;
            m_N = b_count;
        end
        pend = 0;
    end

    // per-cycle comparison and flash model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (m_act) begin
                chk("R2 cs_n active", int'(spi_cs_n), 0);
                chk("R2 sclk phase", int'(spi_sclk), m_k % 2);
                chk("R3 mosi bit", int'(spi_mosi), int'(mtx[m_k / 2]));
                if (m_k % 2 == 0) spi_miso = mrx[m_k / 2];
            end else begin
                chk("R2 cs_n idle", int'(spi_cs_n), 1);
                chk("R2 sclk idle", int'(spi_sclk), 0);
            end
        end
    end

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 5'(a);
        reg_wdata = 8'(v);
        if (a == 0 && (v[2] || v[5])) pend = 1;
        if (a == 1) b_count = v;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        #1;
        reg_addr = 5'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic load_tx(input logic [7:0] b5, b4, b3, b2, b1, b0);
        b_tx[5] = b5; b_tx[4] = b4; b_tx[3] = b3;
        b_tx[2] = b2; b_tx[1] = b1; b_tx[0] = b0;
        for (int i = 0; i < 6; i++) wr(8 + i, int'(b_tx[i]));
        for (int i = 0; i < 256; i++) begin
            if (i < 48) mtx[i] = b_tx[5 - i / 8][7 - i % 8];
            else mtx[i] = 1'b0;
        end
    endtask

    task automatic put_byte(input int pos, input logic [7:0] v);
        for (int b = 0; b < 8; b++) mrx[pos + b] = v[7 - b];
    endtask

    function automatic int exp_rx(input int n, input int j);
        int r = 0;
        for (int b = 0; b < 8; b++) begin
            int idx = n - 1 - 8 * j - b;
            if (idx >= 0 && mrx[idx]) r |= (1 << b);
        end
        return r;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        for (int i = 0; i < 256; i++) begin mtx[i] = 0; mrx[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 sclk", int'(spi_sclk), 0);
        chk("R1 irq", int'(irq), 0);
        rd(0, v); chk("R1 cmd", v, 0);
        rd(1, v); chk("R1 count", v, 0);
        rd(2, v); chk("R1 irq status", v, 0);
        rd(13, v); chk("R1 tx5", v, 0);
        rd(16, v); chk("R1 rx0", v, 0);

        // R2 R3 R4 R5: opcode plus 3-byte reply
        load_tx(8'h9F, 0, 0, 0, 0, 0);
        wr(1, 32);
        for (int i = 0; i < 256; i++) mrx[i] = 0;
        put_byte(0, 8'hFF); put_byte(8, 8'hEF); put_byte(16, 8'h40); put_byte(24, 8'h18);
        wr(0, 8'h04);
        rd(0, v); chk("R5 busy first cycle", v, 8'h04);
        repeat (63) @(posedge clk);
        rd(0, v); chk("R5 busy last cycle", v, 8'h04);
        rd(0, v); chk("R5 idle after", v, 0);
        rd(18, v); chk("R4 rx2 first reply byte", v, 8'hEF);
        rd(17, v); chk("R4 rx1", v, 8'h40);
        rd(16, v); chk("R4 rx0 last reply byte", v, 8'h18);
        rd(19, v); chk("R4 rx3 opcode phase", v, exp_rx(32, 3));
        rd(20, v); chk("R4 rx4 never captured", v, 0);
        chk("R7 prog leaves irq low", int'(irq), 0);

        // R3 R4: full 128-bit transaction, zeros after loaded bytes
        load_tx(8'hA5, 8'h3C, 8'h01, 8'hFF, 8'h80, 8'h7E);
        wr(1, 128);
        for (int i = 0; i < 256; i++) mrx[i] = (((i * 7 + 3) % 5) < 2);
        wr(0, 8'h04);
        repeat (262) @(posedge clk);
        rd(0, v); chk("R5 idle after long", v, 0);
        for (int j = 0; j < 10; j++) begin
            rd(16 + j, v); chk($sformatf("R4 rx%0d long", j), v, exp_rx(128, j));
        end

        // R8: restart attempt while busy
        load_tx(8'h05, 0, 0, 0, 0, 0);
        wr(1, 24);
        wr(0, 8'h04);
        repeat (10) @(posedge clk);
        wr(0, 8'h24);
        rd(0, v); chk("R8 kind kept", v, 8'h04);
        repeat (60) @(posedge clk);
        rd(0, v); chk("R8 ends idle", v, 0);
        rd(2, v); chk("R8 no flag", v, 0);

        // R6 R7: status write with enable
        wr(3, 8'h20);
        load_tx(8'h3C, 0, 0, 0, 0, 0);
        wr(1, 16);
        wr(0, 8'h20);
        rd(0, v); chk("R6 status-write busy bit", v, 8'h20);
        repeat (40) @(posedge clk);
        rd(0, v); chk("R6 idle after", v, 0);
        rd(2, v); chk("R7 flag set", v, 8'h20);
        chk("R7 irq pin set", int'(irq), 1);
        wr(2, 8'h20);
        rd(2, v); chk("R7 flag cleared", v, 0);
        chk("R7 irq pin cleared", int'(irq), 0);

        // R7: program with enable set does not flag
        wr(0, 8'h04);
        repeat (40) @(posedge clk);
        rd(2, v); chk("R7 prog no flag", v, 0);

        // R7: status write with enable clear
        wr(3, 0);
        wr(0, 8'h20);
        repeat (40) @(posedge clk);
        rd(2, v); chk("R7 disabled no flag", v, 0);
        rd(3, v); chk("R7 enable reads 0", v, 0);

        // R9: zero count
        wr(3, 8'h20);
        wr(1, 0);
        wr(0, 8'h20);
        rd(0, v); chk("R9 idle at once", v, 0);
        chk("R9 cs_n high", int'(spi_cs_n), 1);
        rd(2, v); chk("R9 flag set", v, 8'h20);
        wr(2, 8'h20);
        repeat (4) @(posedge clk);

        finish_run();
    end
endmodule